// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block gathers requests from a parameterised set of interrupt sources, 96 by default in three 32-bit banks. Source n sits at bit n%32 of bank n/32. Each source passes two gating layers before it can reach the processor:

- an enable bit, which must be one;
- a mask bit, which must be zero.

Any source that is pending, enabled and unmasked drives the single request output high. The lowest-numbered such source wins the vector register.

Sources 1 and up are level inputs. Their pending bit is the input as sampled at the previous clock edge.

Source 0 is an external line with a selectable trigger type. Its pending bit is sticky: it stays set until software writes a one to pending bit 0. The vector register reports the winner's index shifted left by two. A vector of zero can mean either "nothing pending" or "source 0 wins", so software reads pending bit 0 to tell the two cases apart.

Registers are reached through a simple 32-bit strobe port. The port takes one access per cycle and never stalls, so there is no back-pressure. Read data appears on `reg_rdata` one cycle after the read strobe and holds until the next read. A protection bit, when set, blocks every write that is not marked privileged.

Top module: `vic_top`

## Requirements
- R1: After reset, the following are all zero: the enable, mask, pending, protection and trigger-type state, and `reg_rdata`. `irq_out` is low.
- R2: A read with `reg_en`=1 and `reg_we`=0 loads `reg_rdata` at that clock edge with the register's value before the edge. `reg_rdata` holds between reads.
- R3: Enable words are read/write at byte offsets 0x40, 0x44 and 0x48. Mask words are read/write at 0x50, 0x54 and 0x58. The word at offset 0x40+4k (or 0x50+4k) covers sources 32k to 32k+31, with source 32k+j at bit j.
- R4: Pending words are at 0x10, 0x14 and 0x18. For sources 1 and up, the pending bit equals the input as sampled at the previous edge, and writes to these bits have no effect.
- R5: `irq_out` is high exactly when at least one source has pending=1, enable=1 and mask=0.
- R6: The word at offset 0x00 reads as the lowest-numbered eligible source index shifted left by two bits. It reads as zero when no source is eligible.
- R7: When source 0 is the winner, the vector reads zero and pending bit 0 (bit 0 at 0x10) reads one. With nothing pending, pending bit 0 reads zero.
- R8: Pending bit 0 is sticky. A write to 0x10 with data bit 0 set clears it, and data bit 0 clear leaves it alone. If the trigger condition is true in the same cycle as the clear, the pending bit stays set.
- R9: The trigger type is bits 1:0 at offset 0x0C. The encodings are: 00 = input low, 01 = input high, 10 = falling edge (previous sample 1, current 0), 11 = rising edge (previous sample 0, current 1).
- R10: Protection is bit 0 at offset 0x08. While it is one, any write with `reg_priv`=0 is ignored, including writes to the protection register itself.
- R11: Reads of 0x20, 0x24 and 0x28, and of any other unmapped word, return zero. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address; word-aligned accesses only take effect |
| reg_wdata | input | 32 | Write data |
| reg_priv | input | 1 | Access is privileged |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| src_in | input | 96 | Source inputs; bit 0 is the external line |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench goes after several corner cases:

- Source 0 winning while others are also pending. A priority encoder that searched from the top would report the highest index instead.
- A clear of pending bit 0 in the same cycle that its trigger condition holds. A design that let the clear win would drop a request on a held level line.
- Unprivileged writes to enable, trigger type and protection while protection is on. A leak would re-enable masked sources or let protection be turned off.
- Writes to the level pending bits. A design that latched them would keep asserting `irq_out` after the line fell.

Random traffic then mixes source changes, gating writes and edge-trigger types against a bench model.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BANK_W = 32;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  localparam logic [7:0] OFS_VEC  = 8'h00;
  localparam logic [7:0] OFS_PROT = 8'h08;
  localparam logic [7:0] OFS_TRIG = 8'h0C;
  localparam logic [7:0] OFS_PEND = 8'h10;
  localparam logic [7:0] OFS_FIQ  = 8'h20;
  localparam logic [7:0] OFS_EN   = 8'h40;
  localparam logic [7:0] OFS_MASK = 8'h50;
endpackage

// File: rtl/vic_ext_detect.sv
module vic_ext_detect
  import vic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin,
  input  trig_e mode,
  input  logic  clr,
  output logic  pend
);
  logic prev_q;
  logic hit;

  always_comb begin
    unique case (mode)
      TRIG_LOW:  hit = ~pin;
      TRIG_HIGH: hit = pin;
      TRIG_FALL: hit = prev_q & ~pin;
      default:   hit = ~prev_q & pin;
    endcase
  end

  // The trigger condition takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= pin;
      pend   <= hit | (pend & ~clr);
    end
  end
endmodule

// File: rtl/vic_gate_bank.sv
module vic_gate_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pend,
  output logic [W-1:0] en_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] elig
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      if (en_we)   en_q   <= wdata;
      if (mask_we) mask_q <= wdata;
    end
  end

  assign elig = pend & en_q & ~mask_q;
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N  = 96,
  parameter int IW = 7
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // Downward scan: the last match written is the lowest index.
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter  int NUM_BANKS = 3,
  localparam int NSRC      = NUM_BANKS * BANK_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  input  logic            reg_priv,
  output logic [31:0]     reg_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);
  localparam int IDX_W = $clog2(NSRC);

  logic            prot_q;
  trig_e           trig_q;
  logic [NSRC-1:1] lvl_q;
  logic            ext_pend;
  logic            ext_clr;
  logic [NSRC-1:0] pend_all;
  logic [NSRC-1:0] en_all;
  logic [NSRC-1:0] mask_all;
  logic [NSRC-1:0] elig_all;
  logic [IDX_W-1:0] vec_idx;
  logic [31:0]     rd_next;
  logic            aligned;
  logic            wr_ok;
  logic [3:0]      region;
  logic [1:0]      bsel;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign region  = reg_addr[7:4];
  assign bsel    = reg_addr[3:2];
  assign wr_ok   = reg_en & reg_we & aligned & (~prot_q | reg_priv);
  assign ext_clr = wr_ok & (reg_addr == OFS_PEND) & reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      trig_q <= TRIG_LOW;
      lvl_q  <= '0;
    end else begin
      lvl_q <= src_in[NSRC-1:1];
      if (wr_ok && reg_addr == OFS_PROT) prot_q <= reg_wdata[0];
      if (wr_ok && reg_addr == OFS_TRIG) trig_q <= trig_e'(reg_wdata[1:0]);
    end
  end

  vic_ext_detect u_ext (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (src_in[0]),
    .mode  (trig_q),
    .clr   (ext_clr),
    .pend  (ext_pend)
  );

  assign pend_all = {lvl_q, ext_pend};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic en_we, mask_we;
    assign en_we   = wr_ok && region == OFS_EN[7:4]   && bsel == 2'(b);
    assign mask_we = wr_ok && region == OFS_MASK[7:4] && bsel == 2'(b);

    vic_gate_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_we   (en_we),
      .mask_we (mask_we),
      .wdata   (reg_wdata),
      .pend    (pend_all[b*BANK_W +: BANK_W]),
      .en_q    (en_all[b*BANK_W +: BANK_W]),
      .mask_q  (mask_all[b*BANK_W +: BANK_W]),
      .elig    (elig_all[b*BANK_W +: BANK_W])
    );
  end

  vic_prio_enc #(.N(NSRC), .IW(IDX_W)) u_prio (
    .req (elig_all),
    .hit (irq_out),
    .idx (vec_idx)
  );

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (reg_addr == OFS_VEC)       rd_next = {{(32-IDX_W-2){1'b0}}, vec_idx, 2'b00};
      else if (reg_addr == OFS_PROT) rd_next = {31'd0, prot_q};
      else if (reg_addr == OFS_TRIG) rd_next = {30'd0, trig_q};
      else begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bsel == b[1:0]) begin
            if (region == OFS_PEND[7:4]) rd_next = pend_all[b*BANK_W +: BANK_W];
            if (region == OFS_EN[7:4])   rd_next = en_all[b*BANK_W +: BANK_W];
            if (region == OFS_MASK[7:4]) rd_next = mask_all[b*BANK_W +: BANK_W];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                reg_rdata <= '0;
    else if (reg_en && !reg_we) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk #(
  parameter int NSRC = 96,
  parameter int IW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_en,
  input logic            reg_we,
  input logic            reg_priv,
  input logic            irq_out,
  input logic            prot_q,
  input logic [1:0]      trig_q,
  input logic            ext_clr,
  input logic [NSRC-1:0] pend_all,
  input logic [NSRC-1:0] en_all,
  input logic [NSRC-1:0] mask_all,
  input logic [NSRC-1:0] elig_all,
  input logic [IW-1:0]   vec_idx
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (en_all == '0 && mask_all == '0 && !prot_q && trig_q == 2'b00 && !irq_out));

  a_r5_irq_gating: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((pend_all & en_all & ~mask_all) != '0));

  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (elig_all[vec_idx] && (elig_all & ~({NSRC{1'b1}} << vec_idx)) == '0));

  a_r8_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all[0] && !ext_clr) |=> pend_all[0]);

  a_r10_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && reg_en && reg_we && !reg_priv)
      |=> ($stable(en_all) && $stable(mask_all) && $stable(trig_q) && prot_q));
endmodule

bind vic_top vic_top_chk #(.NSRC(NSRC), .IW(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_en   (reg_en),
  .reg_we   (reg_we),
  .reg_priv (reg_priv),
  .irq_out  (irq_out),
  .prot_q   (prot_q),
  .trig_q   (trig_q),
  .ext_clr  (ext_clr),
  .pend_all (pend_all),
  .en_all   (en_all),
  .mask_all (mask_all),
  .elig_all (elig_all),
  .vec_idx  (vec_idx)
);

// File: tb/sim_vic_top.sv
`timescale 1ns/1ps
module sim_vic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0, reg_priv = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [95:0] src_in = 96'h1;
  logic        irq_out;

  int checks = 0, fails = 0;

  // bench model
  logic [95:0] m_en = '0, m_mask = '0;
  logic [95:1] m_lvl = '0;
  logic        m_ext = 1'b0, m_prev = 1'b0, m_prot = 1'b0;
  logic [1:0]  m_trig = 2'b00;

  always #2.5 clk = ~clk;

  vic_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_priv(reg_priv),
    .reg_rdata(reg_rdata), .src_in(src_in), .irq_out(irq_out)
  );

  function automatic logic [95:0] m_elig();
    return {m_lvl, m_ext} & m_en & ~m_mask;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [95:0] e, p;
    e = m_elig();
    p = {m_lvl, m_ext};
    exp_rd = '0;
    case (a)
      8'h00: for (int i = 95; i >= 0; i--) if (e[i]) exp_rd = i << 2;
      8'h08: exp_rd = {31'd0, m_prot};
      8'h0C: exp_rd = {30'd0, m_trig};
      8'h10, 8'h14, 8'h18: exp_rd = p[(a - 8'h10) * 8 +: 32];
      8'h40, 8'h44, 8'h48: exp_rd = m_en[(a - 8'h40) * 8 +: 32];
      8'h50, 8'h54, 8'h58: exp_rd = m_mask[(a - 8'h50) * 8 +: 32];
      default: exp_rd = '0;
    endcase
  endfunction

  task automatic cyc();
    logic wr_ok, hit, clr;
    wr_ok = reg_en && reg_we && (!m_prot || reg_priv);
    case (m_trig)
      2'b00: hit = !src_in[0];
      2'b01: hit = src_in[0];
      2'b10: hit = m_prev && !src_in[0];
      default: hit = !m_prev && src_in[0];
    endcase
    clr = wr_ok && reg_addr == 8'h10 && reg_wdata[0];
    @(posedge clk);
    m_ext  = hit | (m_ext & !clr);
    m_prev = src_in[0];
    m_lvl  = src_in[95:1];
    if (wr_ok) begin
      case (reg_addr)
        8'h08: m_prot = reg_wdata[0];
        8'h0C: m_trig = reg_wdata[1:0];
        8'h40, 8'h44, 8'h48: m_en[(reg_addr - 8'h40) * 8 +: 32] = reg_wdata;
        8'h50, 8'h54, 8'h58: m_mask[(reg_addr - 8'h50) * 8 +: 32] = reg_wdata;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic priv);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_priv = priv;
    cyc();
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = exp_rd(a);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    cyc();
    reg_en = 1'b0;
    check(tag, reg_rdata, e);
  endtask

  task automatic irq_chk(input string tag);
    check(tag, {31'd0, irq_out}, {31'd0, |m_elig()});
  endtask

  task automatic set_src(input logic [95:0] v);
    src_in = v;
    cyc();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] addrs [14];
    logic [31:0] held;
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h24,
              8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    check("R1 rdata", reg_rdata, 32'd0);
    rst_n = 1'b1;
    rd_chk(8'h00, "R1 vector");
    rd_chk(8'h08, "R1 prot");
    rd_chk(8'h0C, "R1 trig");
    rd_chk(8'h10, "R1 pend");
    rd_chk(8'h44, "R1 enable");
    rd_chk(8'h58, "R1 mask");

    // R2 R3 gating registers
    wr(8'h44, 32'hA5A5_0F0F, 1'b0);
    rd_chk(8'h44, "R3 enable bank1");
    wr(8'h58, 32'h1234_5678, 1'b0);
    rd_chk(8'h58, "R3 mask bank2");
    held = reg_rdata;
    cyc();
    check("R2 rdata holds", reg_rdata, held);

    // R4 level pending
    wr(8'h58, 32'h0, 1'b0);
    set_src(96'h1 | (96'h1 << 40));
    rd_chk(8'h14, "R4 level pend bit8 bank1");
    wr(8'h14, 32'hFFFF_FFFF, 1'b0);
    rd_chk(8'h14, "R4 write ignored");

    // R5 R6 priority and gating
    wr(8'h40, 32'hFFFF_FFFE, 1'b0);
    wr(8'h44, 32'hFFFF_FFFF, 1'b0);
    wr(8'h48, 32'hFFFF_FFFF, 1'b0);
    set_src(96'h1 | (96'h1 << 40) | (96'h1 << 70));
    rd_chk(8'h00, "R6 vector lowest 40");
    irq_chk("R5 irq high");
    wr(8'h54, 32'h0000_0100, 1'b0);
    rd_chk(8'h00, "R6 vector after mask 70");
    wr(8'h48, 32'h0, 1'b0);
    irq_chk("R5 irq low all gated");
    rd_chk(8'h00, "R6 vector none");

    // R7 R8 R9 source 0
    wr(8'h40, 32'h1, 1'b0);
    wr(8'h0C, 32'h3, 1'b0);
    rd_chk(8'h0C, "R9 trig rise");
    set_src(96'h0);
    set_src(96'h1 | (96'h1 << 5));
    wr(8'h40, 32'h21, 1'b0);
    rd_chk(8'h10, "R9 rising sets pend0");
    rd_chk(8'h00, "R7 vector zero src0 wins");
    irq_chk("R7 irq");
    set_src(96'h0);
    rd_chk(8'h10, "R8 sticky after fall");
    wr(8'h10, 32'h0, 1'b0);
    rd_chk(8'h10, "R8 zero write keeps");
    wr(8'h10, 32'h1, 1'b0);
    rd_chk(8'h10, "R8 clear");
    rd_chk(8'h00, "R7 vector zero none");
    wr(8'h0C, 32'h1, 1'b0);
    set_src(96'h1);
    wr(8'h10, 32'h1, 1'b0);
    rd_chk(8'h10, "R8 set wins over clear");
    wr(8'h0C, 32'h2, 1'b0);
    wr(8'h10, 32'h1, 1'b0);
    set_src(96'h0);
    rd_chk(8'h10, "R9 falling sets");

    // R10 protection
    wr(8'h08, 32'h1, 1'b1);
    wr(8'h44, 32'hDEAD_BEEF, 1'b0);
    rd_chk(8'h44, "R10 unpriv enable ignored");
    wr(8'h08, 32'h0, 1'b0);
    rd_chk(8'h08, "R10 unpriv prot ignored");
    wr(8'h44, 32'h0000_F00F, 1'b1);
    rd_chk(8'h44, "R10 priv write");
    wr(8'h08, 32'h0, 1'b1);
    rd_chk(8'h08, "R10 prot off");

    // R11 unmapped
    wr(8'h24, 32'hFFFF_FFFF, 1'b0);
    rd_chk(8'h24, "R11 fiq reads zero");
    rd_chk(8'h44, "R11 fiq write no effect");
    rd_chk(8'h60, "R11 unmapped");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: set_src({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom});
        1: wr(8'h40 + 8'($urandom_range(0, 2) * 4), $urandom, 1'($urandom));
        2: wr(8'h50 + 8'($urandom_range(0, 2) * 4), $urandom & $urandom, 1'($urandom));
        3: wr(8'h10, $urandom, 1'($urandom));
        4: wr(($urandom_range(0, 7) == 0) ? 8'h08 : 8'h0C, $urandom, 1'($urandom));
        default: src_in[0] = ~src_in[0];
      endcase
      rd_chk(addrs[$urandom_range(0, 13)], "R6 random read");
      irq_chk("R5 random irq");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule